// File: doc/BRIEF.md
# Single-Cycle RV32I Control Decoder

This block is the combinational control unit of a single-cycle RV32I datapath. It looks at the 32-bit instruction word and at two flags from the branch comparator (operands equal, first operand less than second). From these it drives every steering signal the datapath needs: the next-PC choice, the immediate format, the register write enable, the comparator signedness, both ALU operand selects, the ALU operation, the memory direction and the write-back source. The register file, ALU, immediate generator and both memories sit outside it.

Branch resolution happens inside the decoder. The comparator flags come straight back in, and the next-PC select is resolved in the same cycle from the branch kind in funct3. The block has no clock and holds no state. The house naming and layout are kept, and the state-machine part of the style does not apply. The instruction class takes the place of a state. Each class is named in the requirements with the output vector it produces, and there are no transitions. Outputs that the datapath does not use for a class are tied to zero, so every vector is fully defined.

Top module: `rvctl_decoder`

Field encodings used throughout:
- pc_sel: 0 = PC+4, 1 = ALU result.
- a_sel: 0 = register, 1 = PC.
- b_sel: 0 = register, 1 = immediate.
- mem_wr: 0 = read, 1 = write.
- wb_sel: 0 = memory data, 1 = ALU result, 2 = PC+4.
- imm_sel: I=0, S=1, B=2, U=3, J=4.
- alu_sel: ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9, PASSB=10.

## Requirements
- R1: Opcode 0110011 (register-register) gives reg_wen=1, a_sel=0, b_sel=0, wb_sel=1, mem_wr=0, pc_sel=0, imm_sel=0, br_unsigned=0. alu_sel follows funct3 (instr[14:12]): 000 gives ADD, or SUB when instr[30]=1; 001 SLL; 010 SLT; 011 SLTU; 100 XOR; 101 gives SRL, or SRA when instr[30]=1; 110 OR; 111 AND.
- R2: Opcode 0010011 (register-immediate arithmetic) gives imm_sel=0, a_sel=0, b_sel=1, reg_wen=1, wb_sel=1, mem_wr=0, pc_sel=0. alu_sel follows the R1 funct3 map, except that funct3 000 is always ADD whatever instr[30] holds.
- R3: Opcode 0000011 (load) gives imm_sel=0, a_sel=0, b_sel=1, alu_sel=ADD, reg_wen=1, mem_wr=0, wb_sel=0, pc_sel=0.
- R4: Opcode 0100011 (store) gives imm_sel=1, b_sel=1, a_sel=0, alu_sel=ADD, mem_wr=1, reg_wen=0, wb_sel=0, pc_sel=0.
- R5: Opcode 1100011 (branch) gives imm_sel=2, a_sel=1, b_sel=1, alu_sel=ADD, reg_wen=0, mem_wr=0, wb_sel=0.
- R6: For a branch, pc_sel=1 exactly when funct3 000 sees eq=1, funct3 001 sees eq=0, or funct3 100 or 110 sees lt=1. Otherwise pc_sel=0.
- R7: br_unsigned is 1 only for a branch with funct3 110, and 0 for funct3 100 and for every other instruction. A branch whose funct3 is not 000, 001, 100 or 110 is never taken.
- R8: Opcode 1101111 (jal) gives imm_sel=4, a_sel=1; opcode 1100111 (jalr) gives imm_sel=0, a_sel=0. Both give b_sel=1, alu_sel=ADD, reg_wen=1, wb_sel=2, pc_sel=1, mem_wr=0, whatever the comparator flags.
- R9: Opcode 0110111 (lui) gives imm_sel=3, a_sel=0, b_sel=1, alu_sel=PASSB. Opcode 0010111 (auipc) gives imm_sel=3, a_sel=1, b_sel=1, alu_sel=ADD. Both give reg_wen=1, wb_sel=1, pc_sel=0, mem_wr=0.
- R10: Any other opcode, including the all-zero word, drives every output to 0, so it acts as a no-op. The comparator flags have no effect on any instruction that is not a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| cmp_eq | input | 1 | Comparator: operands equal |
| cmp_lt | input | 1 | Comparator: first operand less than second |
| pc_sel | output | 1 | Next-PC source |
| imm_sel | output | 3 | Immediate format for the generator |
| reg_wen | output | 1 | Register file write enable |
| br_unsigned | output | 1 | Comparator works unsigned |
| a_sel | output | 1 | ALU operand A source |
| b_sel | output | 1 | ALU operand B source |
| alu_sel | output | 4 | ALU operation |
| mem_wr | output | 1 | Data memory direction |
| wb_sel | output | 2 | Write-back source |

## Verification
The bench checks each branch kind with its condition both true and false. A decoder that swapped the sense of eq for bne, or ignored lt for the unsigned form, would jump on the wrong path. It also drives add and addi with instr[30] set. A decoder that let the immediate's bit 30 pick subtraction would turn an add-immediate into a subtract. Jumps and non-branch instructions are fed comparator flags set to 1, which catches resolution logic that leaks outside branches. An unknown opcode carrying those same flags must still not write a register or memory, and must not redirect the PC.

// File: rtl/rvctl_pkg.sv
package rvctl_pkg;

    localparam int ILEN     = 32;
    localparam int OPC_W    = 7;
    localparam int F3_W     = 3;
    localparam int IMMSEL_W = 3;
    localparam int ALUSEL_W = 4;
    localparam int WBSEL_W  = 2;

    localparam logic [OPC_W-1:0] OPC_REG   = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM   = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BR    = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL   = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR  = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_LUI   = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC = 7'b0010111;

    typedef enum logic [3:0] {
        CLS_NONE, CLS_REG, CLS_IMM, CLS_LOAD, CLS_STORE,
        CLS_BR, CLS_JAL, CLS_JALR, CLS_LUI, CLS_AUIPC
    } inst_cls_t;

    typedef enum logic [IMMSEL_W-1:0] {
        IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4
    } imm_fmt_t;

    typedef enum logic [ALUSEL_W-1:0] {
        ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
        ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
        ALU_OR = 4'd8, ALU_AND = 4'd9, ALU_PASSB = 4'd10
    } alu_op_t;

    typedef enum logic [WBSEL_W-1:0] {
        WB_MEM = 2'd0, WB_ALU = 2'd1, WB_PC4 = 2'd2
    } wb_src_t;

    localparam logic [F3_W-1:0] BF_EQ  = 3'b000;
    localparam logic [F3_W-1:0] BF_NE  = 3'b001;
    localparam logic [F3_W-1:0] BF_LT  = 3'b100;
    localparam logic [F3_W-1:0] BF_LTU = 3'b110;

endpackage

// File: rtl/rvctl_class_dec.sv
module rvctl_class_dec
    import rvctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output inst_cls_t        cls
);
    always_comb begin
        unique case (opcode)
            OPC_REG:   cls = CLS_REG;
            OPC_IMM:   cls = CLS_IMM;
            OPC_LOAD:  cls = CLS_LOAD;
            OPC_STORE: cls = CLS_STORE;
            OPC_BR:    cls = CLS_BR;
            OPC_JAL:   cls = CLS_JAL;
            OPC_JALR:  cls = CLS_JALR;
            OPC_LUI:   cls = CLS_LUI;
            OPC_AUIPC: cls = CLS_AUIPC;
            default:   cls = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/rvctl_alu_dec.sv
module rvctl_alu_dec
    import rvctl_pkg::*;
(
    input  inst_cls_t       cls,
    input  logic [F3_W-1:0] funct3,
    input  logic            alt_bit,
    output alu_op_t         alu_op
);
    alu_op_t arith_op;
    logic    sub_ok;

    // Subtraction is only encodable in the register-register form.
    assign sub_ok = (cls == CLS_REG) && alt_bit;

    always_comb begin
        unique case (funct3)
            3'b000:  arith_op = sub_ok ? ALU_SUB : ALU_ADD;
            3'b001:  arith_op = ALU_SLL;
            3'b010:  arith_op = ALU_SLT;
            3'b011:  arith_op = ALU_SLTU;
            3'b100:  arith_op = ALU_XOR;
            3'b101:  arith_op = alt_bit ? ALU_SRA : ALU_SRL;
            3'b110:  arith_op = ALU_OR;
            default: arith_op = ALU_AND;
        endcase
    end

    always_comb begin
        unique case (cls)
            CLS_REG, CLS_IMM: alu_op = arith_op;
            CLS_LUI:          alu_op = ALU_PASSB;
            default:          alu_op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/rvctl_branch_res.sv
module rvctl_branch_res
    import rvctl_pkg::*;
(
    input  inst_cls_t       cls,
    input  logic [F3_W-1:0] funct3,
    input  logic            cmp_eq,
    input  logic            cmp_lt,
    output logic            taken,
    output logic            use_unsigned
);
    logic cond;

    always_comb begin
        unique case (funct3)
            BF_EQ:   cond = cmp_eq;
            BF_NE:   cond = !cmp_eq;
            BF_LT,
            BF_LTU:  cond = cmp_lt;
            default: cond = 1'b0;
        endcase
    end

    assign taken        = (cls == CLS_BR) && cond;
    assign use_unsigned = (cls == CLS_BR) && (funct3 == BF_LTU);
endmodule

// File: rtl/rvctl_decoder.sv
module rvctl_decoder
    import rvctl_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        cmp_eq,
    input  logic        cmp_lt,
    output logic        pc_sel,
    output logic [2:0]  imm_sel,
    output logic        reg_wen,
    output logic        br_unsigned,
    output logic        a_sel,
    output logic        b_sel,
    output logic [3:0]  alu_sel,
    output logic        mem_wr,
    output logic [1:0]  wb_sel
);
    inst_cls_t cls;
    alu_op_t   alu_op;
    imm_fmt_t  imm_fmt;
    wb_src_t   wb_src;
    logic      br_taken;
    logic      br_uns;
    logic      unused_fields;

    assign unused_fields = ^{instr[31], instr[29:15], instr[11:7]};

    rvctl_class_dec u_cls (
        .opcode (instr[OPC_W-1:0]),
        .cls    (cls)
    );

    rvctl_alu_dec u_alu (
        .cls     (cls),
        .funct3  (instr[14:12]),
        .alt_bit (instr[30]),
        .alu_op  (alu_op)
    );

    rvctl_branch_res u_br (
        .cls          (cls),
        .funct3       (instr[14:12]),
        .cmp_eq       (cmp_eq),
        .cmp_lt       (cmp_lt),
        .taken        (br_taken),
        .use_unsigned (br_uns)
    );

    always_comb begin
        pc_sel  = 1'b0;
        imm_fmt = IMM_I;
        reg_wen = 1'b0;
        a_sel   = 1'b0;
        b_sel   = 1'b0;
        mem_wr  = 1'b0;
        wb_src  = WB_MEM;
        unique case (cls)
            CLS_REG: begin
                reg_wen = 1'b1;
                wb_src  = WB_ALU;
            end
            CLS_IMM: begin
                reg_wen = 1'b1;
                b_sel   = 1'b1;
                wb_src  = WB_ALU;
            end
            CLS_LOAD: begin
                reg_wen = 1'b1;
                b_sel   = 1'b1;
                wb_src  = WB_MEM;
            end
            CLS_STORE: begin
                imm_fmt = IMM_S;
                b_sel   = 1'b1;
                mem_wr  = 1'b1;
            end
            CLS_BR: begin
                imm_fmt = IMM_B;
                a_sel   = 1'b1;
                b_sel   = 1'b1;
                pc_sel  = br_taken;
            end
            CLS_JAL: begin
                imm_fmt = IMM_J;
                a_sel   = 1'b1;
                b_sel   = 1'b1;
                reg_wen = 1'b1;
                wb_src  = WB_PC4;
                pc_sel  = 1'b1;
            end
            CLS_JALR: begin
                b_sel   = 1'b1;
                reg_wen = 1'b1;
                wb_src  = WB_PC4;
                pc_sel  = 1'b1;
            end
            CLS_LUI: begin
                imm_fmt = IMM_U;
                b_sel   = 1'b1;
                reg_wen = 1'b1;
                wb_src  = WB_ALU;
            end
            CLS_AUIPC: begin
                imm_fmt = IMM_U;
                a_sel   = 1'b1;
                b_sel   = 1'b1;
                reg_wen = 1'b1;
                wb_src  = WB_ALU;
            end
            default: begin
                reg_wen = 1'b0;
            end
        endcase
    end

    assign imm_sel     = imm_fmt;
    assign wb_sel      = wb_src;
    assign alu_sel     = (cls == CLS_NONE) ? ALU_ADD : alu_op;
    assign br_unsigned = br_uns;
endmodule

// File: rtl/rvctl_decoder_chk.sv
module rvctl_decoder_chk (
    input logic [31:0] instr,
    input logic        cmp_eq,
    input logic        cmp_lt,
    input logic        pc_sel,
    input logic [2:0]  imm_sel,
    input logic        reg_wen,
    input logic        br_unsigned,
    input logic        a_sel,
    input logic        b_sel,
    input logic [3:0]  alu_sel,
    input logic        mem_wr,
    input logic [1:0]  wb_sel
);
    logic is_br, is_jump, is_st, known;

    assign is_br   = (instr[6:0] == 7'b1100011);
    assign is_jump = (instr[6:0] == 7'b1101111) || (instr[6:0] == 7'b1100111);
    assign is_st   = (instr[6:0] == 7'b0100011);
    assign known   = is_br || is_jump || is_st ||
                     (instr[6:0] == 7'b0110011) || (instr[6:0] == 7'b0010011) ||
                     (instr[6:0] == 7'b0000011) || (instr[6:0] == 7'b0110111) ||
                     (instr[6:0] == 7'b0010111);

    always_comb begin
        // R4: a memory write only for stores, which never write a register
        a_r4_store_only: assert (!mem_wr || (is_st && !reg_wen));
        // R8: a redirect outside branches only happens for jumps writing PC+4
        a_r8_jump_redirect: assert (!pc_sel || is_br || (is_jump && wb_sel == 2'd2));
        // R6: a taken branch agrees with the comparator flags
        a_r6_branch_cond: assert (!(is_br && pc_sel) ||
            (instr[14:12] == 3'b000 && cmp_eq) || (instr[14:12] == 3'b001 && !cmp_eq) ||
            ((instr[14:12] == 3'b100 || instr[14:12] == 3'b110) && cmp_lt));
        // R7: unsigned compare only for the unsigned branch kind
        a_r7_unsigned: assert (!br_unsigned || (is_br && instr[14:12] == 3'b110));
        // R10: unknown opcodes are silent
        a_r10_noop: assert (known || (!reg_wen && !mem_wr && !pc_sel && imm_sel == 3'd0 &&
                                      !a_sel && !b_sel && alu_sel == 4'd0 && wb_sel == 2'd0));
        // R5: branches never write the register file
        a_r5_branch_nowrite: assert (!is_br || (!reg_wen && a_sel && b_sel && imm_sel == 3'd2));
    end
endmodule

bind rvctl_decoder rvctl_decoder_chk u_chk (
    .instr       (instr),
    .cmp_eq      (cmp_eq),
    .cmp_lt      (cmp_lt),
    .pc_sel      (pc_sel),
    .imm_sel     (imm_sel),
    .reg_wen     (reg_wen),
    .br_unsigned (br_unsigned),
    .a_sel       (a_sel),
    .b_sel       (b_sel),
    .alu_sel     (alu_sel),
    .mem_wr      (mem_wr),
    .wb_sel      (wb_sel)
);

// File: tb/rvctl_decoder_tb.sv
module rvctl_decoder_tb;

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                       input logic [6:0] op);
        return {f7, 10'd0, f3, 5'd0, op};
    endfunction

    // packed expectation: pc, imm, rwen, bu, a, b, alu, mw, wb
    function automatic logic [14:0] ex(input logic pc, input logic [2:0] imm,
                                       input logic rw, input logic bu, input logic a,
                                       input logic b, input logic [3:0] alu,
                                       input logic mw, input logic [1:0] wb);
        return {pc, imm, rw, bu, a, b, alu, mw, wb};
    endfunction

    localparam int NV = 22;
    // {instr, eq, lt, expected}
    localparam logic [48:0] VEC [NV] = '{
        {mk(7'h00,3'd0,7'h33), 2'b00, ex(0,3'd0,1,0,0,0,4'd0,0,2'd1)},  // R1 add
        {mk(7'h20,3'd0,7'h33), 2'b00, ex(0,3'd0,1,0,0,0,4'd1,0,2'd1)},  // R1 sub
        {mk(7'h20,3'd5,7'h33), 2'b00, ex(0,3'd0,1,0,0,0,4'd7,0,2'd1)},  // R1 sra
        {mk(7'h00,3'd0,7'h33), 2'b11, ex(0,3'd0,1,0,0,0,4'd0,0,2'd1)},  // R10 flags ignored
        {mk(7'h20,3'd0,7'h13), 2'b00, ex(0,3'd0,1,0,0,1,4'd0,0,2'd1)},  // R2 addi bit30
        {mk(7'h20,3'd5,7'h13), 2'b00, ex(0,3'd0,1,0,0,1,4'd7,0,2'd1)},  // R2 srai
        {mk(7'h00,3'd7,7'h13), 2'b11, ex(0,3'd0,1,0,0,1,4'd9,0,2'd1)},  // R2 andi
        {mk(7'h00,3'd2,7'h03), 2'b11, ex(0,3'd0,1,0,0,1,4'd0,0,2'd0)},  // R3 lw
        {mk(7'h00,3'd2,7'h23), 2'b11, ex(0,3'd1,0,0,0,1,4'd0,1,2'd0)},  // R4 sw
        {mk(7'h00,3'd0,7'h63), 2'b10, ex(1,3'd2,0,0,1,1,4'd0,0,2'd0)},  // R6 beq taken
        {mk(7'h00,3'd0,7'h63), 2'b01, ex(0,3'd2,0,0,1,1,4'd0,0,2'd0)},  // R6 beq not
        {mk(7'h00,3'd1,7'h63), 2'b00, ex(1,3'd2,0,0,1,1,4'd0,0,2'd0)},  // R6 bne taken
        {mk(7'h00,3'd1,7'h63), 2'b10, ex(0,3'd2,0,0,1,1,4'd0,0,2'd0)},  // R6 bne not
        {mk(7'h00,3'd4,7'h63), 2'b01, ex(1,3'd2,0,0,1,1,4'd0,0,2'd0)},  // R7 blt taken
        {mk(7'h00,3'd4,7'h63), 2'b10, ex(0,3'd2,0,0,1,1,4'd0,0,2'd0)},  // R7 blt not
        {mk(7'h00,3'd6,7'h63), 2'b01, ex(1,3'd2,0,1,1,1,4'd0,0,2'd0)},  // R7 bltu taken
        {mk(7'h00,3'd6,7'h63), 2'b10, ex(0,3'd2,0,1,1,1,4'd0,0,2'd0)},  // R7 bltu not
        {mk(7'h00,3'd0,7'h6F), 2'b00, ex(1,3'd4,1,0,1,1,4'd0,0,2'd2)},  // R8 jal
        {mk(7'h00,3'd0,7'h67), 2'b11, ex(1,3'd0,1,0,0,1,4'd0,0,2'd2)},  // R8 jalr
        {mk(7'h00,3'd0,7'h37), 2'b11, ex(0,3'd3,1,0,0,1,4'd10,0,2'd1)}, // R9 lui
        {mk(7'h00,3'd0,7'h17), 2'b00, ex(0,3'd3,1,0,1,1,4'd0,0,2'd1)},  // R9 auipc
        {mk(7'h7F,3'd7,7'h7F), 2'b11, ex(0,3'd0,0,0,0,0,4'd0,0,2'd0)}   // R10 unknown
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'd0;
    logic        cmp_eq = 1'b0;
    logic        cmp_lt = 1'b0;
    logic        pc_sel, reg_wen, br_unsigned, a_sel, b_sel, mem_wr;
    logic [2:0]  imm_sel;
    logic [3:0]  alu_sel;
    logic [1:0]  wb_sel;
    int          n_tests = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #4 clk = ~clk;

    rvctl_decoder u_dut (
        .instr(instr), .cmp_eq(cmp_eq), .cmp_lt(cmp_lt), .pc_sel(pc_sel),
        .imm_sel(imm_sel), .reg_wen(reg_wen), .br_unsigned(br_unsigned),
        .a_sel(a_sel), .b_sel(b_sel), .alu_sel(alu_sel), .mem_wr(mem_wr),
        .wb_sel(wb_sel)
    );

    function automatic logic [14:0] got();
        return {pc_sel, imm_sel, reg_wen, br_unsigned, a_sel, b_sel, alu_sel, mem_wr, wb_sel};
    endfunction

    task automatic apply_check(input logic [31:0] i, input logic eq, input logic lt,
                               input logic [14:0] exp, input string tag);
        @(posedge clk);
        #1;
        instr  = i;
        cmp_eq = eq;
        cmp_lt = lt;
        @(negedge clk);
        n_tests++;
        if (got() !== exp) begin
            n_fail++;
            $display("FAIL %s instr=%h actual=%h expected=%h", tag, i, got(), exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10: all-zero word after reset acts as a no-op
        @(negedge clk);
        n_tests++;
        if (got() !== 15'd0) begin
            n_fail++;
            $display("FAIL R10 reset word actual=%h expected=%h", got(), 15'd0);
        end

        for (int k = 0; k < NV; k++)
            apply_check(VEC[k][48:17], VEC[k][16], VEC[k][15], VEC[k][14:0], "table");

        // R1: every register-register funct3 mapping
        for (int f = 0; f < 8; f++) begin
            logic [3:0] op;
            case (f)
                0: op = 4'd0; 1: op = 4'd2; 2: op = 4'd3; 3: op = 4'd4;
                4: op = 4'd5; 5: op = 4'd6; 6: op = 4'd8; default: op = 4'd9;
            endcase
            apply_check(mk(7'h00, 3'(f), 7'h33), 1'b0, 1'b0,
                        ex(0,3'd0,1,0,0,0,op,0,2'd1), "R1 funct3");
        end

        // R7: unsupported branch kinds are never taken
        apply_check(mk(7'h00,3'd5,7'h63), 1'b1, 1'b1,
                    ex(0,3'd2,0,0,1,1,4'd0,0,2'd0), "R7 bge-kind");
        apply_check(mk(7'h00,3'd7,7'h63), 1'b1, 1'b1,
                    ex(0,3'd2,0,0,1,1,4'd0,0,2'd0), "R7 bgeu-kind");
        // R5: branch with both flags clear keeps fixed steering
        apply_check(mk(7'h00,3'd0,7'h63), 1'b0, 1'b0,
                    ex(0,3'd2,0,0,1,1,4'd0,0,2'd0), "R5 branch steering");
        // R8: jal unaffected by flags
        apply_check(mk(7'h00,3'd0,7'h6F), 1'b1, 1'b1,
                    ex(1,3'd4,1,0,1,1,4'd0,0,2'd2), "R8 jal flags");
        // R10: another unknown opcode
        apply_check(mk(7'h00,3'd0,7'h0F), 1'b1, 1'b0,
                    ex(0,3'd0,0,0,0,0,4'd0,0,2'd0), "R10 fence-like");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule